// File: doc/BRIEF.md
# Command-Driven SPI Master

This block is a single-lane SPI master controlled through a small 32-bit register window. Software pushes words into a four-entry transmit queue. It then writes a command word that carries the frame length, the clock mode, the target select line and the direction enables, with the start bit set. The engine shifts one frame of 1 to 32 bits out on MOSI, most significant bit first, and samples MISO on the opposite clock edge. The received frame is pushed, right-aligned, into a four-entry receive queue, and a sticky ready flag is raised.

Four active-low select lines are provided. In hardware mode the chosen line is low for the whole frame. In software mode the chosen line follows a level bit in the command word. Queue misuse is recorded in sticky flags with a summary bit. Software clears these flags by writing back the value it read. SCK is derived from the system clock with a half period of CLK_DIV+1 cycles.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset the select lines are all high, SCK is low, the command register reads 0x0010_0000, transfer status reads 0, and queue status reads 0x005 (bit 0 receive empty, bit 2 transmit empty).
- R2: A command written to offset 0x000 with bit 31 set starts a frame of (bits 4:0)+1 bits. The frame takes the low N bits of the transmit queue head, sends them MSB first and produces exactly N SCK periods.
- R3: Command bits 29:28 give the mode, with bit 29 as clock polarity and bit 28 as clock phase. SCK idles at the polarity level. With phase 0 MISO and MOSI are sampled on the leading edge; with phase 1 they are sampled on the trailing edge.
- R4: When receive is enabled (bit 12), the received bits are pushed to the receive queue right-aligned, with the first bit in bit N-1 and zeros above. They are read at offset 0x188.
- R5: Transfer status bit 30 at offset 0x010 is set once the received word has been pushed. It stays set until 1 is written to that bit.
- R6: The start bit self-clears when the frame begins, so command bit 31 reads 0 while the frame runs.
- R7: With bit 21 clear, only the line selected by bits 27:26 goes low, and only for the duration of the frame. At most one line is low at any time.
- R8: With bit 21 set, the selected line follows bit 20 and the other lines stay high.
- R9: A start with transmit enabled (bit 11) and an empty transmit queue sets the tx underrun flag (bit 6) and sends zeros.
- R10: A write to offset 0x108 while the transmit queue is full sets tx overflow (bit 7), and the word is dropped.
- R11: A read of offset 0x188 while the receive queue is empty returns zero and sets rx underrun (bit 4).
- R12: A frame that completes with receive enabled and the receive queue full sets rx overflow (bit 5). Bit 1 reports receive full and bit 3 reports transmit full.
- R13: Queue status bit 8 is set whenever any of bits 7:4 is set. Writing 1s to bits 7:4 at offset 0x014 clears those flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low select lines |

## Verification
The bench wires MISO to the inverse of MOSI and reconstructs the outgoing bits with an edge monitor. It runs frames of 1, 5, 8, 12, 16 and 32 bits in all four modes. A design that misaligns short frames, swaps bit order or samples on the wrong edge therefore shows a wrong receive word, a wrong monitor word or the wrong SCK edge count. Changing the mode between frames would produce a stray SCK edge if the idle level were handled wrongly. The queue edges are each driven on purpose: a start with an empty transmit queue, a fifth transmit write, a fifth received frame and a read of an empty receive queue. A design with a missing flag, a summary bit that does not follow the flags, or flags that do not clear on write-back is caught by an exact status value.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int XLEN   = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CMD   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_XSTAT = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_QSTAT = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_TXQ   = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_RXQ   = 12'h188;

    localparam int B_GO     = 31;
    localparam int B_CPOL   = 29;
    localparam int B_CPHA   = 28;
    localparam int B_SEL_LO = 26;
    localparam int B_SWCS   = 21;
    localparam int B_SWLVL  = 20;
    localparam int B_RXEN   = 12;
    localparam int B_TXEN   = 11;
    localparam int B_RDY    = 30;

    localparam logic [XLEN-1:0] CMD_MASK  = 32'h7C30_181F;
    localparam logic [XLEN-1:0] CMD_RESET = 32'h0010_0000;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_DONE = 2'd2
    } eng_state_e;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full_o  = (s_q.cnt == CNT_W'(DEPTH));
    assign empty_o = (s_q.cnt == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem_q[s_q.rd];

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.wr = (s_q.wr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == PTR_W'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[s_q.wr] <= data_i;
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_cmd_pkg::*;
#(
    parameter int CLK_DIV = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] word_i,
    input  logic [4:0]      len_m1_i,
    input  logic            cpol_i,
    input  logic            cpha_i,
    input  logic            miso_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] rx_word_o,
    output logic            sck_o,
    output logic            mosi_o
);
    localparam int CNT_W  = $clog2(CLK_DIV + 2);
    localparam int EDGE_W = 6;

    typedef struct packed {
        eng_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [EDGE_W-1:0] edge_idx;
        logic [XLEN-1:0]   sh;
        logic [XLEN-1:0]   rx;
        logic [4:0]        len_m1;
        logic              cpha;
        logic              sck;
    } eng_st_t;

    eng_st_t s_d, s_q;
    logic leading, sample_now;

    always_comb begin
        s_d        = s_q;
        done_o     = 1'b0;
        leading    = (s_q.edge_idx[0] == 1'b0);
        sample_now = leading ^ s_q.cpha;
        case (s_q.state)
            ENG_IDLE: begin
                s_d.sck = cpol_i;
                if (start_i) begin
                    s_d.sh       = word_i << (5'd31 - len_m1_i);
                    s_d.rx       = '0;
                    s_d.cnt      = '0;
                    s_d.edge_idx = '0;
                    s_d.len_m1   = len_m1_i;
                    s_d.cpha     = cpha_i;
                    s_d.state    = ENG_RUN;
                end
            end
            ENG_RUN: begin
                if (s_q.cnt == CNT_W'(CLK_DIV)) begin
                    s_d.cnt = '0;
                    s_d.sck = ~s_q.sck;
                    if (sample_now) begin
                        s_d.rx = {s_q.rx[XLEN-2:0], miso_i};
                    end else if (s_q.edge_idx != '0) begin
                        s_d.sh = {s_q.sh[XLEN-2:0], 1'b0};
                    end
                    if (s_q.edge_idx == {s_q.len_m1, 1'b1}) begin
                        s_d.state = ENG_DONE;
                    end else begin
                        s_d.edge_idx = s_q.edge_idx + 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ENG_DONE: begin
                done_o    = 1'b1;
                s_d.sck   = cpol_i;
                s_d.state = ENG_IDLE;
            end
            default: s_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ENG_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = (s_q.state != ENG_IDLE);
    assign rx_word_o = s_q.rx;
    assign sck_o     = s_q.sck;
    assign mosi_o    = s_q.sh[XLEN-1];
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
    import spi_cmd_pkg::*;
#(
    parameter int NUM_CS     = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int CLK_DIV    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [XLEN-1:0]   reg_wdata,
    output logic [XLEN-1:0]   reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    typedef struct packed {
        logic [XLEN-1:0] cmd;
        logic            go;
        logic            ready;
        logic            tx_unr;
        logic            tx_ovf;
        logic            rx_unr;
        logic            rx_ovf;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_cmd, wr_xstat, wr_qstat, wr_tx, rd_rx;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [XLEN-1:0] tx_head, rx_head, eng_rx;
    logic eng_busy, eng_done, eng_start;
    logic cpol, cpha, rx_en, tx_en, sw_cs, sw_lvl;
    logic [1:0] cs_sel;
    logic err_any;
    logic go_w, ready_w, tx_ovf_w, rx_unr_w;

    assign wr_cmd   = reg_wr && (reg_addr == OFS_CMD);
    assign wr_xstat = reg_wr && (reg_addr == OFS_XSTAT);
    assign wr_qstat = reg_wr && (reg_addr == OFS_QSTAT);
    assign wr_tx    = reg_wr && (reg_addr == OFS_TXQ);
    assign rd_rx    = reg_rd && (reg_addr == OFS_RXQ);

    assign cpol   = r_q.cmd[B_CPOL];
    assign cpha   = r_q.cmd[B_CPHA];
    assign rx_en  = r_q.cmd[B_RXEN];
    assign tx_en  = r_q.cmd[B_TXEN];
    assign sw_cs  = r_q.cmd[B_SWCS];
    assign sw_lvl = r_q.cmd[B_SWLVL];
    assign cs_sel = r_q.cmd[B_SEL_LO+1:B_SEL_LO];

    assign eng_start = r_q.go && !eng_busy;
    assign err_any   = r_q.tx_unr | r_q.tx_ovf | r_q.rx_unr | r_q.rx_ovf;

    assign go_w     = r_q.go;
    assign ready_w  = r_q.ready;
    assign tx_ovf_w = r_q.tx_ovf;
    assign rx_unr_w = r_q.rx_unr;

    spi_word_fifo #(.WIDTH(XLEN), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (wr_tx),
        .data_i (reg_wdata),
        .pop_i  (eng_start && tx_en),
        .head_o (tx_head),
        .full_o (tx_full),
        .empty_o(tx_empty)
    );

    spi_word_fifo #(.WIDTH(XLEN), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (eng_done && rx_en),
        .data_i (eng_rx),
        .pop_i  (rd_rx),
        .head_o (rx_head),
        .full_o (rx_full),
        .empty_o(rx_empty)
    );

    spi_shift_engine #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (eng_start),
        .word_i   ((tx_en && !tx_empty) ? tx_head : '0),
        .len_m1_i (r_q.cmd[4:0]),
        .cpol_i   (cpol),
        .cpha_i   (cpha),
        .miso_i   (spi_miso),
        .busy_o   (eng_busy),
        .done_o   (eng_done),
        .rx_word_o(eng_rx),
        .sck_o    (spi_sck),
        .mosi_o   (spi_mosi)
    );

    always_comb begin
        r_d = r_q;
        if (eng_start) begin
            r_d.go = 1'b0;
        end
        if (wr_cmd) begin
            r_d.cmd = reg_wdata & CMD_MASK;
            r_d.go  = reg_wdata[B_GO];
        end
        if (wr_xstat && reg_wdata[B_RDY]) begin
            r_d.ready = 1'b0;
        end
        if (wr_qstat) begin
            if (reg_wdata[4]) r_d.rx_unr = 1'b0;
            if (reg_wdata[5]) r_d.rx_ovf = 1'b0;
            if (reg_wdata[6]) r_d.tx_unr = 1'b0;
            if (reg_wdata[7]) r_d.tx_ovf = 1'b0;
        end
        if (eng_done) begin
            r_d.ready = 1'b1;
        end
        if (eng_start && tx_en && tx_empty) begin
            r_d.tx_unr = 1'b1;
        end
        if (wr_tx && tx_full) begin
            r_d.tx_ovf = 1'b1;
        end
        if (rd_rx && rx_empty) begin
            r_d.rx_unr = 1'b1;
        end
        if (eng_done && rx_en && rx_full) begin
            r_d.rx_ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.cmd <= CMD_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD:   reg_rdata = r_q.cmd | {r_q.go, {(XLEN-1){1'b0}}};
            OFS_XSTAT: reg_rdata[B_RDY] = r_q.ready;
            OFS_QSTAT: reg_rdata[8:0] = {err_any, r_q.tx_ovf, r_q.tx_unr,
                                         r_q.rx_ovf, r_q.rx_unr, tx_full,
                                         tx_empty, rx_full, rx_empty};
            OFS_RXQ:   reg_rdata = rx_empty ? '0 : rx_head;
            default:   reg_rdata = '0;
        endcase
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        always_comb begin
            if (cs_sel != 2'(g)) begin
                spi_cs_n[g] = 1'b1;
            end else if (sw_cs) begin
                spi_cs_n[g] = sw_lvl;
            end else begin
                spi_cs_n[g] = !eng_busy;
            end
        end
    end
endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sck,
    input logic              busy,
    input logic              cpol,
    input logic              go,
    input logic              ready,
    input logic              rx_en,
    input logic              rx_empty,
    input logic              tx_full,
    input logic              wr_tx,
    input logic              tx_ovf,
    input logic              rd_rx,
    input logic              rx_unr
);
    AST_CS_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1); // R7

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(cpol)) |-> (sck == cpol)); // R3

    AST_GO_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy); // R6

    AST_READY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && rx_en) |-> !rx_empty); // R5

    AST_TX_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && tx_full) |=> tx_ovf); // R10

    AST_RX_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && rx_empty) |=> rx_unr); // R11
endmodule

bind spi_cmd_master spi_cmd_master_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (spi_cs_n),
    .sck     (spi_sck),
    .busy    (eng_busy),
    .cpol    (cpol),
    .go      (go_w),
    .ready   (ready_w),
    .rx_en   (rx_en),
    .rx_empty(rx_empty),
    .tx_full (tx_full),
    .wr_tx   (wr_tx),
    .tx_ovf  (tx_ovf_w),
    .rd_rx   (rd_rx),
    .rx_unr  (rx_unr_w)
);

// File: tb/sim_spi_cmd_master.sv
module sim_spi_cmd_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [3:0]  spi_cs_n;

    int n_checks = 0;
    int n_errors = 0;
    logic        finished = 1'b0;

    always #4 clk = ~clk;

    assign spi_miso = ~spi_mosi;

    spi_cmd_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // Edge monitor: rebuilds the outgoing word from the bus pins
    logic        mon_arm = 1'b0;
    logic        cur_cpol = 1'b0;
    logic        cur_cpha = 1'b0;
    logic [31:0] mon_word = '0;
    int          mon_edges = 0;
    logic [3:0]  mon_cs = 4'hF;

    always @(spi_sck) begin
        if (mon_arm) begin
            mon_edges = mon_edges + 1;
            if ((spi_sck != cur_cpol) ^ cur_cpha) begin
                mon_word = {mon_word[30:0], spi_mosi};
                mon_cs   = spi_cs_n;
            end
        end
    end

    typedef struct packed {
        logic [1:0]  mode;
        logic [4:0]  len;
        logic [31:0] tx;
        logic [31:0] rx;
        logic [31:0] mon;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 5'd7,  32'h0000_00A5, 32'h0000_005A, 32'h0000_00A5},
        '{2'd1, 5'd15, 32'h0000_1234, 32'h0000_EDCB, 32'h0000_1234},
        '{2'd2, 5'd31, 32'hDEAD_BEEF, 32'h2152_4110, 32'hDEAD_BEEF},
        '{2'd3, 5'd0,  32'hFFFF_FFFE, 32'h0000_0001, 32'h0000_0000},
        '{2'd0, 5'd4,  32'hFFFF_FFF3, 32'h0000_000C, 32'h0000_0013},
        '{2'd1, 5'd11, 32'h0000_0ABC, 32'h0000_0543, 32'h0000_0ABC}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_rd   = 1'b1;
        #2;
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] mk_cmd(input logic go, input logic [1:0] mode,
            input logic [1:0] cs, input logic sw, input logic lvl,
            input logic rxen, input logic txen, input logic [4:0] len);
        return {go, 1'b1, mode, cs, 4'b0, sw, lvl, 7'b0, rxen, txen, 6'b0, len};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready(input string req);
        logic [31:0] v;
        v = '0;
        for (int k = 0; k < 3000; k++) begin
            reg_read(12'h010, v);
            if (v[30]) break;
        end
        check(req, {31'b0, v[30]}, 32'h1);
    endtask

    task automatic start_frame(input logic [1:0] mode, input logic [1:0] cs,
            input logic rxen, input logic txen, input logic [4:0] len);
        reg_write(12'h000, mk_cmd(1'b0, mode, cs, 1'b0, 1'b1, rxen, txen, len));
        repeat (2) @(negedge clk);
        cur_cpol  = mode[1];
        cur_cpha  = mode[0];
        mon_word  = '0;
        mon_edges = 0;
        mon_cs    = 4'hF;
        mon_arm   = 1'b1;
        reg_write(12'h000, mk_cmd(1'b1, mode, cs, 1'b0, 1'b1, rxen, txen, len));
    endtask

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        check("R1 cs_n", {28'b0, spi_cs_n}, 32'hF);
        check("R1 sck", {31'b0, spi_sck}, 32'h0);
        reg_read(12'h000, v); check("R1 cmd", v, 32'h0010_0000);
        reg_read(12'h010, v); check("R1 xstat", v, 32'h0);
        reg_read(12'h014, v); check("R1 qstat", v, 32'h5);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] cs;
            cs = 2'(i);
            reg_write(12'h108, VEC[i].tx);
            start_frame(VEC[i].mode, cs, 1'b1, 1'b1, VEC[i].len);
            reg_read(12'h000, v);
            check("R6 go self-clears", {31'b0, v[31]}, 32'h0);
            wait_ready("R5 ready set");
            repeat (2) @(negedge clk);
            mon_arm = 1'b0;
            check("R2 mosi word msb first", mon_word, VEC[i].mon);
            check("R2 sck periods", 32'(mon_edges), 32'(2 * (int'(VEC[i].len) + 1)));
            check("R7 selected line low", {28'b0, mon_cs}, {28'b0, ~(4'b1 << cs)});
            check("R7 lines released", {28'b0, spi_cs_n}, 32'hF);
            check("R3 sck idle level", {31'b0, spi_sck}, {31'b0, VEC[i].mode[1]});
            reg_read(12'h188, v); check("R4 rx right-aligned", v, VEC[i].rx);
            reg_write(12'h010, 32'h4000_0000);
            reg_read(12'h010, v); check("R5 ready cleared", v, 32'h0);
            reg_read(12'h014, v); check("R4 queues drained", v, 32'h5);
        end

        // R8 software chip select
        reg_write(12'h000, mk_cmd(1'b0, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd7));
        @(negedge clk);
        check("R8 sw level low", {28'b0, spi_cs_n}, 32'hB);
        reg_write(12'h000, mk_cmd(1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 5'd7));
        @(negedge clk);
        check("R8 sw level high", {28'b0, spi_cs_n}, 32'hF);

        // R9 tx underrun, R13 summary and clear
        start_frame(2'd0, 2'd0, 1'b0, 1'b1, 5'd7);
        wait_ready("R9 frame completes");
        repeat (2) @(negedge clk);
        mon_arm = 1'b0;
        check("R9 zeros sent", mon_word, 32'h0);
        reg_read(12'h014, v); check("R9 R13 underrun flags", v, 32'h145);
        reg_write(12'h014, v);
        reg_read(12'h014, v); check("R13 write-back clears", v, 32'h5);

        // R10 tx overflow
        do_reset();
        for (int k = 0; k < 5; k++) reg_write(12'h108, 32'h100 + 32'(k));
        reg_read(12'h014, v); check("R10 overflow flags", v, 32'h189);
        reg_write(12'h014, 32'h180);
        reg_read(12'h014, v); check("R10 R13 cleared", v, 32'h9);

        // R11 rx underrun
        do_reset();
        reg_read(12'h188, v); check("R11 empty read zero", v, 32'h0);
        reg_read(12'h014, v); check("R11 underrun flags", v, 32'h115);

        // R12 rx overflow
        do_reset();
        for (int k = 0; k < 5; k++) begin
            start_frame(2'd0, 2'd1, 1'b1, 1'b0, 5'd7);
            wait_ready("R12 frame completes");
            mon_arm = 1'b0;
            reg_write(12'h010, 32'h4000_0000);
        end
        reg_read(12'h014, v); check("R12 overflow flags", v, 32'h126);
        reg_read(12'h188, v); check("R12 kept word", v, 32'hFF);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule